// File: doc/BRIEF.md
# Binary Up Counter with Asynchronous Parallel Preset

A small synchronous binary up counter, three bits wide by default, whose state can be forced at any moment through an active-low load strobe. Each bit is a toggle stage. A carry chain gates the toggles, so bit i flips on a clock edge only when every lower bit is 1 and counting is enabled. The load path does not use the clock. While the strobe is low, every bit is driven by its own asynchronous set or clear. A bit whose preset value is 1 is set, and a bit whose preset value is 0 is cleared.

While the strobe stays low, the state tracks the preset value and clock edges do nothing. When the strobe returns high, the counter keeps the loaded value. It counts up from that value on the first clock edge at which the strobe is sampled high. A count-enable input freezes the state on clock edges but has no effect on the load path. An active-low asynchronous reset clears the counter and overrides the load.

Top module: `ctr_preset`

## Requirements
- R1: While rst_ni is low, count_o is 0, even when load_ni is also low.
- R2: On a rising clock edge with load_ni high and en_i high, count_o becomes its previous value plus one.
- R3: The count wraps from the all-ones value (7 at the default width) to 0.
- R4: On a rising clock edge with load_ni high and en_i low, count_o keeps its value.
- R5: When load_ni goes low, count_o takes the value of preset_i at once, with no clock edge. Bit i is set when preset_i[i] is 1 and cleared when it is 0.
- R6: A clock edge at which load_ni is low has no effect, and count_o stays equal to preset_i.
- R7: While load_ni is low, a change on preset_i appears on count_o without any clock edge.
- R8: While load_ni is high, preset_i has no effect on count_o.
- R9: After load_ni returns high, count_o holds the loaded value until the next edge. On the first edge at which load_ni is sampled high, counting resumes from the loaded value, so loading 5 from state 2 gives 5 and then 6.
- R10: With en_i low, a low level on load_ni still loads preset_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Asynchronous parallel load strobe, active low |
| preset_i | input | WIDTH | Value forced into the state while loading |
| en_i | input | 1 | Count enable for clock edges |
| count_o | output | WIDTH | Current count |

## Verification
On every clock edge, the assertions check the increment with wrap-around, the hold when counting is disabled, and that the state equals the preset value whenever the load strobe is sampled low, whether or not counting is enabled. Some behaviour happens between clock edges and can only be shown by the bench's scenarios. These are the immediate response to a falling load strobe, the state following the preset value when it changes mid-cycle, and the reset overriding an active load. The value held right after the strobe is released, before the next edge, is also checked only by the bench.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned CTR_W_DEF = 3;
endpackage

// File: rtl/ctr_load_decode.sv
module ctr_load_decode #(
  parameter int unsigned WIDTH = ctr_pkg::CTR_W_DEF
) (
  input  logic             load_ni,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] set_no,
  output logic [WIDTH-1:0] clr_no
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign set_no[i] = load_ni |  ~preset_i[i];
    assign clr_no[i] = load_ni |   preset_i[i];
  end
endmodule

// File: rtl/ctr_carry_chain.sv
module ctr_carry_chain #(
  parameter int unsigned WIDTH = ctr_pkg::CTR_W_DEF
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] tgl_o
);
  assign tgl_o[0] = en_i;
  for (genvar i = 1; i < WIDTH; i++) begin : g_carry
    assign tgl_o[i] = tgl_o[i-1] & q_i[i-1];
  end
endmodule

// File: rtl/ctr_toggle_stage.sv
module ctr_toggle_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ni,
  input  logic clr_ni,
  input  logic tgl_i,
  output logic q_o
);
  // reset > clear > set > toggle
  always_ff @(posedge clk_i or negedge rst_ni or negedge set_ni or negedge clr_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (!clr_ni) q_o <= 1'b0;
    else if (!set_ni) q_o <= 1'b1;
    else if (tgl_i)   q_o <= ~q_o;
  end
endmodule

// File: rtl/ctr_preset.sv
module ctr_preset #(
  parameter int unsigned WIDTH = ctr_pkg::CTR_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o
);
  logic [WIDTH-1:0] set_n, clr_n, tgl, q;

  ctr_load_decode #(.WIDTH(WIDTH)) i_decode (
    .load_ni (load_ni),
    .preset_i(preset_i),
    .set_no  (set_n),
    .clr_no  (clr_n)
  );

  ctr_carry_chain #(.WIDTH(WIDTH)) i_carry (
    .en_i (en_i),
    .q_i  (q),
    .tgl_o(tgl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    ctr_toggle_stage i_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_ni(set_n[i]),
      .clr_ni(clr_n[i]),
      .tgl_i (tgl[i]),
      .q_o   (q[i])
    );
  end

  assign count_o = q;

  // R2 / R3: increment modulo 2**WIDTH unless a load intervenes
  assert_count_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_i) |=> (!load_ni || count_o == WIDTH'($past(count_o) + 1'b1)));

  // R4: hold when disabled
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_i) |=> (!load_ni || $stable(count_o)));

  // R6: edges during load leave the preset value in place
  assert_load_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> count_o == preset_i);

  // R10: enable low does not block loading
  assert_load_no_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && !en_i) |-> count_o == preset_i);
endmodule

// File: tb/test_ctr_preset.sv
`timescale 1ns/1ps
module test_ctr_preset;
  localparam int W = 3;
  logic clk_i = 1'b0, rst_ni = 1'b0, load_ni = 1'b1, en_i = 1'b0;
  logic [W-1:0] preset_i = '0;
  logic [W-1:0] count_o;
  logic [W-1:0] exp_q;
  int checks = 0, errors = 0;
  bit done = 0;

  ctr_preset #(.WIDTH(W)) i_ctr_preset (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni),
    .preset_i(preset_i), .en_i(en_i), .count_o(count_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [W-1:0] next_val(logic [W-1:0] v, logic ld_n, logic en,
                                            logic [W-1:0] p);
    if (!ld_n) return p;
    if (en) return v + 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at falling edge, check before and after the next rising edge
  task automatic step(logic ld_n, logic [W-1:0] p, logic en, string req);
    @(negedge clk_i);
    load_ni = ld_n; preset_i = p; en_i = en;
    #1;
    if (!ld_n) exp_q = p;
    check(req, count_o, exp_q);
    @(posedge clk_i); #1;
    exp_q = next_val(exp_q, ld_n, en, p);
    check(req, count_o, exp_q);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    #3;
    check("R1", count_o, 3'd0);
    load_ni = 1'b0; preset_i = 3'd6; #2;
    check("R1", count_o, 3'd0);
    load_ni = 1'b1; #2;
    @(negedge clk_i); rst_ni = 1'b1; exp_q = '0;

    for (int i = 0; i < 9; i++) step(1'b1, 3'd3, 1'b1, "R2");
    check("R3", count_o, 3'd1);
    step(1'b1, 3'd4, 1'b0, "R4");
    step(1'b1, 3'd7, 1'b0, "R8");

    // from 2, load 5, then 6 on release (R9)
    step(1'b0, 3'd2, 1'b1, "R5");
    step(1'b0, 3'd5, 1'b1, "R6");
    step(1'b0, 3'd5, 1'b1, "R6");
    step(1'b1, 3'd0, 1'b1, "R9");
    check("R9", count_o, 3'd6);

    // mid-cycle load, preset change while low
    @(posedge clk_i); #3;
    load_ni = 1'b0; preset_i = 3'd7; #1;
    check("R5", count_o, 3'd7);
    #2; preset_i = 3'd1; #1;
    check("R7", count_o, 3'd1);
    exp_q = 3'd1;
    step(1'b0, 3'd0, 1'b0, "R10");
    step(1'b0, 3'd4, 1'b0, "R10");
    step(1'b1, 3'd4, 1'b0, "R9");
    check("R9", count_o, 3'd4);
    step(1'b1, 3'd4, 1'b1, "R9");
    check("R9", count_o, 3'd5);

    // load to all ones, release, wrap
    step(1'b0, 3'd7, 1'b1, "R6");
    step(1'b1, 3'd2, 1'b1, "R3");
    check("R3", count_o, 3'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic ld_n, en;
      logic [W-1:0] p;
      ld_n = ($urandom % 5) != 0;
      en = ($urandom % 4) != 0;
      p = W'($urandom);
      step(ld_n, p, en, ld_n ? "R8" : "R6");
    end

    // reset overrides active load
    @(negedge clk_i); load_ni = 1'b0; preset_i = 3'd5; #1;
    rst_ni = 1'b0; #1;
    check("R1", count_o, 3'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule